// File: doc/BRIEF.md
# Watchdog Timer with Write-Once Mode Register

This block is a watchdog timer for a small controller. A counter advances on ticks from one of two time bases: an internal RC oscillator tick or an external system clock tick. When it reaches the length set by the selected tap, the block raises a reset request. Software keeps the system alive by pulsing a refresh input, which clears the counter. Two status inputs report whether the core is in HALT or STOP. Separate mode bits decide whether the watchdog keeps counting in each of those states. While the watchdog is paused, the counter keeps its value.

The mode register has a write port only and cannot be read back. It accepts writes only during the first 60 clock cycles after the synchronous reset is released. After that it locks, and it stays locked until the next reset. Reset covers power-on, watchdog and stop-recovery resets alike. A timeout that happens while the core is in STOP does not raise the reset request. It raises a separate stop-timeout pulse, which asks the surrounding logic for its power-up delay.

Top module: `wdt_lockcfg`

## Requirements
- R1: After reset both outputs are low and the mode register holds its default: tap 01, HALT counting on, STOP counting on, RC time base. With RC ticks present, a timeout therefore follows 256 ticks.
- R2: Mode bits [1:0] select the timeout length in ticks of the selected base: 00 gives 128, 01 gives 256, 10 gives 512 and 11 gives 2048. The request goes high in the cycle after the clock edge that samples the final tick.
- R3: A write (strobe high at a clock edge) is accepted at any of the first 60 clock edges after reset is released, numbered 0 to 59. A write at edge 60 or later has no effect until the next reset.
- R4: Bits [7:5] of the write data are ignored. A write whose low bits hold a valid setting takes effect whatever those high bits hold.
- R5: Mode bit 4 selects the time base: 0 counts RC ticks, 1 counts external ticks. Ticks on the base that is not selected never advance the counter.
- R6: A refresh pulse clears the counter, so the next timeout comes a full tap length after the refresh.
- R7: While HALT is high and mode bit 2 is 0, the counter holds its value and counting resumes on exit. With bit 2 set to 1, counting continues during HALT.
- R8: While STOP is high and mode bit 3 is 0, the counter holds its value and counting resumes on exit. With bit 3 set to 1, counting continues during STOP.
- R9: A timeout outside STOP pulses the reset request for exactly one cycle. A timeout during STOP pulses the stop-timeout output for exactly one cycle and leaves the reset request low. In both cases the counter starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (any reset source) |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 8 | Mode register write data |
| kick | input | 1 | Refresh pulse; clears the counter |
| halt | input | 1 | Core is in HALT |
| stop | input | 1 | Core is in STOP |
| rc_tick | input | 1 | Tick from the internal RC time base |
| ext_tick | input | 1 | Tick from the external clock time base |
| wdt_rst | output | 1 | One-cycle reset request on timeout |
| stop_to | output | 1 | One-cycle timeout indication while in STOP |

## Verification
The assertions check on every cycle that, once locked, the register stays locked and its contents never change. They also check that a refresh always leaves the counter at zero and that a paused counter holds its value. For the outputs, they check that each pulse lasts a single cycle, that the two outputs are never high together, and that a stop timeout only comes out of a cycle spent in STOP. Only the bench scenarios can show the actual timeout lengths for each tap and time base, and the exact edge where the write window closes. The same holds for the ignored reserved bits, and for the resumed counts after a HALT or STOP pause.

// File: rtl/wdt_lockcfg_pkg.sv
package wdt_lockcfg_pkg;

  // Stored mode bits; field order follows the write-data bit positions.
  typedef struct packed {
    logic       ext_base;  // bit 4: 1 = external tick, 0 = RC tick
    logic       stop_en;   // bit 3: count during STOP
    logic       halt_en;   // bit 2: count during HALT
    logic [1:0] tap;       // bits 1:0: timeout length select
  } wdt_cfg_t;

  localparam int CFG_BITS = $bits(wdt_cfg_t);

  localparam wdt_cfg_t CFG_DEFAULT = '{
    ext_base: 1'b0,
    stop_en:  1'b1,
    halt_en:  1'b1,
    tap:      2'b01
  };

endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
  import wdt_lockcfg_pkg::*;
#(
  parameter int LOCK_CYCLES = 60,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output wdt_cfg_t          cfg,
  output logic              locked
);

  localparam int WIN_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(LOCK_CYCLES - 1);

  logic [WIN_W-1:0] win_cnt;

  // Window counter and sticky lock flag; only reset reopens the window.
  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
      locked  <= 1'b0;
    end else if (!locked) begin
      if (win_cnt == WIN_LAST) begin
        locked <= 1'b1;
      end else begin
        win_cnt <= win_cnt + 1'b1;
      end
    end
  end

  // Mode register; the reserved upper data bits are never stored.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_DEFAULT;
    end else if (we && !locked) begin
      cfg <= wdt_cfg_t'(wdata[CFG_BITS-1:0]);
    end
  end

  assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(cfg));

endmodule

// File: rtl/wdt_tick_gate.sv
module wdt_tick_gate
  import wdt_lockcfg_pkg::*;
(
  input  wdt_cfg_t cfg,
  input  logic     rc_tick,
  input  logic     ext_tick,
  input  logic     halt,
  input  logic     stop,
  output logic     tick_en,
  output logic     in_stop
);

  logic base_tick;
  logic paused;

  always_comb begin
    base_tick = cfg.ext_base ? ext_tick : rc_tick;
    paused    = (stop && !cfg.stop_en) || (halt && !cfg.halt_en);
    tick_en   = base_tick && !paused;
    in_stop   = stop;
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int TAP0 = 128,
  parameter int TAP1 = 256,
  parameter int TAP2 = 512,
  parameter int TAP3 = 2048
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] tap,
  input  logic       tick_en,
  input  logic       kick,
  input  logic       in_stop,
  output logic       wdt_rst,
  output logic       stop_to
);

  localparam int MAX_A = (TAP0 > TAP1) ? TAP0 : TAP1;
  localparam int MAX_B = (TAP2 > TAP3) ? TAP2 : TAP3;
  localparam int TAP_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(TAP_MAX + 1);
  localparam int NTAPS = 4;

  // Terminal count per tap, built by a generate loop over the tap lengths.
  logic [CNT_W-1:0] last_tbl [NTAPS];

  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    localparam int LEN = (g == 0) ? TAP0 : (g == 1) ? TAP1 : (g == 2) ? TAP2 : TAP3;
    assign last_tbl[g] = CNT_W'(LEN - 1);
  end

  logic [CNT_W-1:0] count;
  logic             hit;

  assign hit = tick_en && (count >= last_tbl[tap]);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      wdt_rst <= 1'b0;
      stop_to <= 1'b0;
    end else begin
      wdt_rst <= 1'b0;
      stop_to <= 1'b0;
      if (kick) begin
        count <= '0;
      end else if (hit) begin
        count <= '0;
        if (in_stop) begin
          stop_to <= 1'b1;
        end else begin
          wdt_rst <= 1'b1;
        end
      end else if (tick_en) begin
        count <= count + 1'b1;
      end
    end
  end

  assert_kick_clear_R6: assert property (@(posedge clk) disable iff (rst)
    kick |=> (count == '0));

  assert_pause_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !kick) |=> $stable(count));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (wdt_rst || stop_to) |=> !(wdt_rst || stop_to));

  assert_outputs_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(wdt_rst && stop_to));

  assert_stop_route_R9: assert property (@(posedge clk) disable iff (rst)
    stop_to |-> $past(in_stop));

endmodule

// File: rtl/wdt_lockcfg.sv
module wdt_lockcfg
  import wdt_lockcfg_pkg::*;
#(
  parameter int LOCK_CYCLES = 60,
  parameter int DATA_W      = 8,
  parameter int TAP0        = 128,
  parameter int TAP1        = 256,
  parameter int TAP2        = 512,
  parameter int TAP3        = 2048
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              kick,
  input  logic              halt,
  input  logic              stop,
  input  logic              rc_tick,
  input  logic              ext_tick,
  output logic              wdt_rst,
  output logic              stop_to
);

  wdt_cfg_t cfg;
  logic     locked;
  logic     tick_en;
  logic     in_stop;

  wdt_cfg_reg #(
    .LOCK_CYCLES (LOCK_CYCLES),
    .DATA_W      (DATA_W)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .cfg    (cfg),
    .locked (locked)
  );

  wdt_tick_gate u_gate (
    .cfg      (cfg),
    .rc_tick  (rc_tick),
    .ext_tick (ext_tick),
    .halt     (halt),
    .stop     (stop),
    .tick_en  (tick_en),
    .in_stop  (in_stop)
  );

  wdt_counter #(
    .TAP0 (TAP0),
    .TAP1 (TAP1),
    .TAP2 (TAP2),
    .TAP3 (TAP3)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tap     (cfg.tap),
    .tick_en (tick_en),
    .kick    (kick),
    .in_stop (in_stop),
    .wdt_rst (wdt_rst),
    .stop_to (stop_to)
  );

  assert_no_write_when_locked_R3: assert property (@(posedge clk) disable iff (rst)
    (locked && cfg_we) |=> $stable(cfg));

endmodule

// File: tb/wdt_lockcfg_tb.sv
module wdt_lockcfg_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       kick = 1'b0;
  logic       halt = 1'b0;
  logic       stop = 1'b0;
  logic       rc_tick = 1'b0;
  logic       ext_tick = 1'b0;
  logic       wdt_rst;
  logic       stop_to;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  always #10 clk = ~clk;

  wdt_lockcfg u_dut (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .kick      (kick),
    .halt      (halt),
    .stop      (stop),
    .rc_tick   (rc_tick),
    .ext_tick  (ext_tick),
    .wdt_rst   (wdt_rst),
    .stop_to   (stop_to)
  );

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles >= 190000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reset; on return the next rising edge is edge 0 after release.
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    kick = 1'b0; halt = 1'b0; stop = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_at(input int k, input logic [7:0] d);
    repeat (k) @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_kick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  // Counts edges until the chosen output is seen high; flags the other one.
  task automatic wait_pulse(input bit use_stop, input int lim,
                            output int k, output int other);
    k = 0;
    other = 0;
    forever begin
      @(negedge clk);
      k++;
      if (use_stop ? wdt_rst : stop_to) other = 1;
      if (use_stop ? stop_to : wdt_rst) break;
      if (k > lim) begin
        k = -1;
        break;
      end
    end
  endtask

  task automatic run_ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int tap_len(input int t);
    return (t == 3) ? 2048 : (128 << t);
  endfunction

  initial begin
    int k;
    int other;
    int seen;

    // R1: reset state and default timeout
    do_reset();
    @(negedge clk);
    chk("R1 wdt_rst low after reset", int'(wdt_rst), 0);
    chk("R1 stop_to low after reset", int'(stop_to), 0);
    rc_tick = 1'b1;
    do_kick();
    wait_pulse(1'b0, 3000, k, other);
    chk("R1 default timeout ticks", k, 256);
    @(negedge clk);
    chk("R9 reset request lasts one cycle", int'(wdt_rst), 0);

    // R2 / R5: every tap on both time bases, plus unselected-base immunity
    for (int base = 0; base < 2; base++) begin
      for (int t = 0; t < 4; t++) begin
        rc_tick = 1'b0; ext_tick = 1'b0;
        do_reset();
        write_at(0, 8'(t | 12 | (base << 4)));
        if (t == 0) begin
          rc_tick = (base == 1); ext_tick = (base == 0);
          do_kick();
          seen = 0;
          for (int i = 0; i < 2200; i++) begin
            @(negedge clk);
            if (wdt_rst || stop_to) seen = 1;
          end
          chk($sformatf("R5 unselected base %0d never times out", base), seen, 0);
        end
        rc_tick = (base == 0); ext_tick = (base == 1);
        do_kick();
        wait_pulse(1'b0, 3000, k, other);
        chk($sformatf("R2 base %0d tap %0d ticks", base, t), k, tap_len(t));
      end
    end
    ext_tick = 1'b0;
    rc_tick = 1'b1;

    // R3: write at the last open edge is taken
    do_reset();
    write_at(59, 8'h0C);
    do_kick();
    wait_pulse(1'b0, 3000, k, other);
    chk("R3 write at edge 59 accepted", k, 128);

    // R3: write at edge 60 is ignored
    do_reset();
    write_at(60, 8'h0C);
    do_kick();
    wait_pulse(1'b0, 3000, k, other);
    chk("R3 write at edge 60 ignored", k, 256);

    // R3: a fresh reset reopens the window after a lock
    do_reset();
    write_at(5, 8'h0F);
    run_ticks(100);
    write_at(0, 8'h0C);
    do_kick();
    wait_pulse(1'b0, 3000, k, other);
    chk("R3 late write ignored, tap 11 kept", k, 2048);

    // R4: reserved upper bits do not block the write
    do_reset();
    write_at(0, 8'hEC);
    do_kick();
    wait_pulse(1'b0, 3000, k, other);
    chk("R4 reserved bits ignored", k, 128);

    // R6: a refresh midway restarts the full length
    do_reset();
    do_kick();
    run_ticks(200);
    do_kick();
    wait_pulse(1'b0, 3000, k, other);
    chk("R6 timeout counted from last kick", k, 256);

    // R7: HALT pause with bit 2 clear
    do_reset();
    write_at(0, 8'h08);
    do_kick();
    run_ticks(50);
    halt = 1'b1;
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (wdt_rst || stop_to) seen = 1;
    end
    chk("R7 no timeout while paused in HALT", seen, 0);
    halt = 1'b0;
    wait_pulse(1'b0, 3000, k, other);
    chk("R7 counting resumes after HALT", k, 78);

    // R7: HALT counting with bit 2 set
    do_reset();
    write_at(0, 8'h0C);
    do_kick();
    halt = 1'b1;
    wait_pulse(1'b0, 3000, k, other);
    chk("R7 counts during HALT when enabled", k, 128);
    halt = 1'b0;

    // R8: STOP pause with bit 3 clear
    do_reset();
    write_at(0, 8'h04);
    do_kick();
    run_ticks(30);
    stop = 1'b1;
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (wdt_rst || stop_to) seen = 1;
    end
    chk("R8 no timeout while paused in STOP", seen, 0);
    stop = 1'b0;
    wait_pulse(1'b0, 3000, k, other);
    chk("R8 counting resumes after STOP", k, 98);

    // R8 / R9: STOP counting with bit 3 set yields stop timeout only
    do_reset();
    write_at(0, 8'h0C);
    do_kick();
    stop = 1'b1;
    wait_pulse(1'b1, 3000, k, other);
    chk("R8 stop timeout ticks", k, 128);
    chk("R9 no reset request during STOP", other, 0);
    @(negedge clk);
    chk("R9 stop timeout lasts one cycle", int'(stop_to), 0);
    wait_pulse(1'b1, 3000, k, other);
    chk("R9 counter reloads after stop timeout", k, 127);
    stop = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule